// File: doc/BRIEF.md
# Programmable Parallel Port Interface

A bus-attached peripheral with three 8-bit parallel ports and one control word, selected by a 2-bit register address. The control word sets the direction of each port: the first port as a whole, the second port as a whole, and the third port as two nibbles that are set apart from each other. Each port has a pin input bus, an output latch bus and a per-bit output-enable. Software writes to a port change its latch only when that port is an output. Reads return live pins for input ports and the latch for output ports. The third port is read per nibble from either source.

A control write with bit 7 set loads a new direction word. A control write with bit 7 clear leaves the direction word alone and sets or clears one bit of the third port's latch instead. Handshake modes, bidirectional transfers and interrupts are not part of the block.

The direction of each port is an enumerated state held in the control register. That state is either `DIR_OUT` or `DIR_IN`. The only transition is a mode-definition write, which moves every port to the state its control bit names. Reset puts all four fields into `DIR_IN`.

Top module: `ppi_port_ctl`

## Requirements
- R1: Register address 0 reads port A, 1 reads port B, 2 reads port C and 3 reads the control word.
- R2: While reset is held and after it is released, the control word reads 8'h9B, all output latches are zero and every output-enable is low.
- R3: Control bit 4 set makes port A an input (pa_oe all zero). A write to address 0 then leaves pa_out unchanged. With bit 4 clear, pa_oe is all ones and a write to address 0 appears on pa_out one clock later.
- R4: Control bit 1 set makes port B an input (pb_oe all zero). A write to address 1 then leaves pb_out unchanged. With bit 1 clear, pb_oe is all ones and a write appears on pb_out one clock later.
- R5: A read of port A or port B returns its pin input when the port is an input, and its output latch when the port is an output.
- R6: Control bit 0 set makes port C bits [3:0] inputs and bit 3 set makes bits [7:4] inputs. pc_oe is all ones for each nibble that is an output and zero for each nibble that is an input.
- R7: A read of port C returns, for each nibble, the pin value if that nibble is an input and the latched value if it is an output.
- R8: A write to address 2 loads the whole port C latch whatever the nibble directions, and shows on pc_out one clock later.
- R9: A write to address 3 with data bit 7 set stores the whole data byte as the control word, and it reads back unchanged.
- R10: A write to address 3 with data bit 7 clear sets port C latch bit wdata[3:1] to wdata[0]. It leaves the other latch bits and the control word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe for one cycle |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register (combinational) |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-bit output-enable |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-bit output-enable |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output-enable, uniform within each nibble |

## Verification
The bench walks all sixteen direction combinations. For each one it sets the pins and the latches to differing patterns, so that a read served from the wrong source, or from a swapped nibble, gives a visible mismatch. Writes to input ports are checked at pa_out and pb_out. A design that did not drop these writes would show the written data there. The bit set/reset sweep covers every bit index with both values and reads the control word back. A design that treated such a write as a mode word, or decoded the bit index wrongly, would corrupt the control word or the neighbouring latch bits. Reset is applied a second time after dirty state, to catch latches or a control value that reset does not restore.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } sel_e;

    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } dir_e;

    typedef struct packed {
        dir_e a;
        dir_e b;
        dir_e c_lo;
        dir_e c_hi;
    } dir_cfg_t;

    localparam int CW_W        = 8;
    localparam int BIT_MODE    = 7;
    localparam int BIT_A_IN    = 4;
    localparam int BIT_CHI_IN  = 3;
    localparam int BIT_B_IN    = 1;
    localparam int BIT_CLO_IN  = 0;
    localparam logic [CW_W-1:0] CTRL_RESET = 8'h9B;
    localparam int NUM_PORTS   = 3;
endpackage

// File: rtl/ppi_ctrl_reg.sv
module ppi_ctrl_reg
    import ppi_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [CW_W-1:0] wdata,
    output logic [CW_W-1:0] ctrl_q,
    output dir_cfg_t        dirs
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else if (load) begin
            ctrl_q <= wdata;
        end
    end

    always_comb begin
        dirs.a    = dir_e'(ctrl_q[BIT_A_IN]);
        dirs.b    = dir_e'(ctrl_q[BIT_B_IN]);
        dirs.c_lo = dir_e'(ctrl_q[BIT_CLO_IN]);
        dirs.c_hi = dir_e'(ctrl_q[BIT_CHI_IN]);
    end
endmodule

// File: rtl/ppi_port_latch.sv
module ppi_port_latch #(
    parameter int PORT_W = 8,
    localparam int IDX_W = $clog2(PORT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PORT_W-1:0] wdata,
    input  logic              bit_wr,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              bit_val,
    output logic [PORT_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= wdata;
        end else if (bit_wr) begin
            q[bit_idx] <= bit_val;
        end
    end
endmodule

// File: rtl/ppi_read_mux.sv
module ppi_read_mux
    import ppi_pkg::*;
#(
    parameter int PORT_W = 8,
    localparam int HALF = PORT_W / 2
) (
    input  sel_e              sel,
    input  dir_cfg_t          dirs,
    input  logic [CW_W-1:0]   ctrl_q,
    input  logic [PORT_W-1:0] a_lat,
    input  logic [PORT_W-1:0] b_lat,
    input  logic [PORT_W-1:0] c_lat,
    input  logic [PORT_W-1:0] a_pin,
    input  logic [PORT_W-1:0] b_pin,
    input  logic [PORT_W-1:0] c_pin,
    output logic [PORT_W-1:0] rdata
);
    logic [HALF-1:0] c_lo_rd;
    logic [HALF-1:0] c_hi_rd;

    always_comb begin
        c_lo_rd = (dirs.c_lo == DIR_IN) ? c_pin[HALF-1:0]      : c_lat[HALF-1:0];
        c_hi_rd = (dirs.c_hi == DIR_IN) ? c_pin[PORT_W-1:HALF] : c_lat[PORT_W-1:HALF];
    end

    always_comb begin
        unique case (sel)
            SEL_A:    rdata = (dirs.a == DIR_IN) ? a_pin : a_lat;
            SEL_B:    rdata = (dirs.b == DIR_IN) ? b_pin : b_lat;
            SEL_C:    rdata = {c_hi_rd, c_lo_rd};
            SEL_CTRL: rdata = PORT_W'(ctrl_q);
            default:  rdata = '1;
        endcase
    end
endmodule

// File: rtl/ppi_port_ctl.sv
module ppi_port_ctl
    import ppi_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pb_oe,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] pc_out,
    output logic [PORT_W-1:0] pc_oe
);
    localparam int HALF  = PORT_W / 2;
    localparam int IDX_W = $clog2(PORT_W);

    sel_e            sel;
    dir_cfg_t        dirs;
    logic [CW_W-1:0] ctrl_q;
    logic            mode_wr;
    logic            bsr_wr;

    logic              lat_load [NUM_PORTS];
    logic              lat_bit  [NUM_PORTS];
    logic [PORT_W-1:0] lat_q    [NUM_PORTS];

    assign sel     = sel_e'(addr);
    assign mode_wr = wr_en && (sel == SEL_CTRL) &&  wdata[BIT_MODE];
    assign bsr_wr  = wr_en && (sel == SEL_CTRL) && !wdata[BIT_MODE];

    ppi_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (mode_wr),
        .wdata  (CW_W'(wdata)),
        .ctrl_q (ctrl_q),
        .dirs   (dirs)
    );

    always_comb begin
        lat_load[0] = wr_en && (sel == SEL_A) && (dirs.a == DIR_OUT);
        lat_load[1] = wr_en && (sel == SEL_B) && (dirs.b == DIR_OUT);
        lat_load[2] = wr_en && (sel == SEL_C);
        lat_bit[0]  = 1'b0;
        lat_bit[1]  = 1'b0;
        lat_bit[2]  = bsr_wr;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lat
        ppi_port_latch #(.PORT_W(PORT_W)) u_lat (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (lat_load[p]),
            .wdata   (wdata),
            .bit_wr  (lat_bit[p]),
            .bit_idx (wdata[IDX_W:1]),
            .bit_val (wdata[0]),
            .q       (lat_q[p])
        );
    end

    ppi_read_mux #(.PORT_W(PORT_W)) u_rd (
        .sel    (sel),
        .dirs   (dirs),
        .ctrl_q (ctrl_q),
        .a_lat  (lat_q[0]),
        .b_lat  (lat_q[1]),
        .c_lat  (lat_q[2]),
        .a_pin  (pa_in),
        .b_pin  (pb_in),
        .c_pin  (pc_in),
        .rdata  (rdata)
    );

    always_comb begin
        pa_out = lat_q[0];
        pb_out = lat_q[1];
        pc_out = lat_q[2];
        pa_oe  = {PORT_W{dirs.a == DIR_OUT}};
        pb_oe  = {PORT_W{dirs.b == DIR_OUT}};
        pc_oe  = {{HALF{dirs.c_hi == DIR_OUT}}, {HALF{dirs.c_lo == DIR_OUT}}};
    end
endmodule

// File: rtl/ppi_port_ctl_chk.sv
module ppi_port_ctl_chk
    import ppi_pkg::*;
#(
    parameter int PORT_W = 8,
    localparam int IDX_W = $clog2(PORT_W),
    localparam int HALF  = PORT_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        addr,
    input logic [PORT_W-1:0] wdata,
    input logic [PORT_W-1:0] rdata,
    input logic [PORT_W-1:0] pa_in,
    input logic [PORT_W-1:0] pa_out,
    input logic [PORT_W-1:0] pb_out,
    input logic [PORT_W-1:0] pc_out,
    input logic [PORT_W-1:0] pc_oe,
    input logic [CW_W-1:0]   ctrl_q
);
    AST_A_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0 && ctrl_q[BIT_A_IN]) |=> $stable(pa_out)); // R3
    AST_A_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0 && !ctrl_q[BIT_A_IN]) |=> (pa_out == $past(wdata))); // R3
    AST_B_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1 && ctrl_q[BIT_B_IN]) |=> $stable(pb_out)); // R4
    AST_A_READ_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd0 && ctrl_q[BIT_A_IN]) |-> (rdata == pa_in)); // R5
    AST_PC_OE_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pc_oe[HALF-1:0] == '0 || pc_oe[HALF-1:0] == '1) &&
         (pc_oe[PORT_W-1:HALF] == '0 || pc_oe[PORT_W-1:HALF] == '1))); // R6
    AST_C_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd2) |=> (pc_out == $past(wdata))); // R8
    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3 && wdata[BIT_MODE]) |=> (ctrl_q == CW_W'($past(wdata)))); // R9
    AST_BSR_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3 && !wdata[BIT_MODE]) |=> $stable(ctrl_q)); // R10
    AST_BSR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3 && !wdata[BIT_MODE]) |=>
        (pc_out[$past(wdata[IDX_W:1])] == $past(wdata[0]))); // R10
endmodule

bind ppi_port_ctl ppi_port_ctl_chk #(.PORT_W(PORT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .pa_in  (pa_in),
    .pa_out (pa_out),
    .pb_out (pb_out),
    .pc_out (pc_out),
    .pc_oe  (pc_oe),
    .ctrl_q (ctrl_q)
);

// File: tb/sim_ppi_port_ctl.sv
module sim_ppi_port_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ppi_port_ctl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic reset_check();
        logic [7:0] v;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd3, v);
        chk("R2 ctrl", v, 8'h9B);
        chk("R2 pa_out", pa_out, 8'h00);
        chk("R2 pb_out", pb_out, 8'h00);
        chk("R2 pc_out", pc_out, 8'h00);
        chk("R2 oe", pa_oe | pb_oe | pc_oe, 8'h00);
    endtask

    initial begin
        #(8 * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] la, lb, lc, v, ctrl, exp_c;
        la = 0; lb = 0; lc = 0;
        reset_check();

        for (int i = 0; i < 16; i++) begin
            logic a_in, b_in, clo_in, chi_in;
            logic [7:0] da, db, dc;
            a_in = i[0]; b_in = i[1]; clo_in = i[2]; chi_in = i[3];
            ctrl = 8'h80 | (8'(a_in) << 4) | (8'(b_in) << 1) | 8'(clo_in) | (8'(chi_in) << 3)
                 | (8'(i[1]) << 6) | (8'(i[0]) << 5) | (8'(i[2]) << 2);
            wr(2'd3, ctrl);
            rd(2'd3, v);
            chk("R9 ctrl readback", v, ctrl);
            chk("R3 pa_oe", pa_oe, a_in ? 8'h00 : 8'hFF);
            chk("R4 pb_oe", pb_oe, b_in ? 8'h00 : 8'hFF);
            chk("R6 pc_oe", pc_oe, {chi_in ? 4'h0 : 4'hF, clo_in ? 4'h0 : 4'hF});

            da = (8'h11 * 8'(i)) ^ 8'h5A;
            db = ~da;
            dc = da + 8'h37;
            wr(2'd0, da); if (!a_in) la = da;
            wr(2'd1, db); if (!b_in) lb = db;
            wr(2'd2, dc); lc = dc;
            pa_in = 8'hC3 ^ 8'(i);
            pb_in = 8'h3C ^ 8'(i << 4);
            pc_in = 8'hA5 ^ 8'(i * 3);
            chk("R3 pa_out", pa_out, la);
            chk("R4 pb_out", pb_out, lb);
            chk("R8 pc_out", pc_out, lc);
            rd(2'd0, v); chk("R1/R5 read A", v, a_in ? pa_in : la);
            rd(2'd1, v); chk("R1/R5 read B", v, b_in ? pb_in : lb);
            exp_c = {chi_in ? pc_in[7:4] : lc[7:4], clo_in ? pc_in[3:0] : lc[3:0]};
            rd(2'd2, v); chk("R1/R7 read C", v, exp_c);
        end

        wr(2'd3, 8'h80);
        for (int b = 0; b < 8; b++) begin
            for (int val = 0; val < 2; val++) begin
                wr(2'd3, {4'h0, 3'(b), 1'(val)});
                lc[b] = 1'(val);
                chk("R10 pc_out", pc_out, lc);
                rd(2'd3, v);
                chk("R10 ctrl kept", v, 8'h80);
                rd(2'd2, v);
                chk("R7 read C latch", v, lc);
            end
        end

        reset_check();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule